// File: doc/BRIEF.md
# Saturating Dual-Step Up Counter

This block is an 8-bit synchronous up counter that moves forward by one or by two on each clock edge where counting is enabled. A mode input picks the step size at run time. The counter does not roll over. When a step would pass the top of its range, the count stays at the highest value that the current mode allows.

In step-by-two mode the output only shows even values. The highest even value is 254. If the mode switches to step-by-two while the count is odd, the next enabled edge moves the count to an even value first. From an odd value below the top it steps up by one. From 255 it drops to 254. After that the count advances by two.

Reset is active-low and synchronous. It clears the count to zero on a rising clock edge and overrides every other input.

Top module: `dual_step_sat_counter`

## Requirements
- R1: On a rising clock edge with `rst_n_i` low, `count_o` becomes 0. This happens whatever the values of `run_i` and `pair_i`. Between edges, reset has no effect.
- R2: On an edge with `rst_n_i` high and `run_i` low, `count_o` keeps its value. This holds even if `pair_i` changes.
- R3: With `run_i` high and `pair_i` low (step by one), each edge adds 1 to `count_o` while it is below 255.
- R4: With `run_i` high and `pair_i` low, a count of 255 stays at 255 and does not wrap.
- R5: With `run_i` high and `pair_i` high (step by two), an even count below 254 increases by 2 on each edge.
- R6: With `run_i` high and `pair_i` high, a count of 254 stays at 254. In this mode no step ever passes 254.
- R7: With `run_i` high and `pair_i` high, an odd count below 255 increases by 1. A count of 255 becomes 254.
- R8: After every enabled edge with `pair_i` high, bit 0 of `count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Count enable, active high |
| pair_i | input | 1 | Step select: 0 steps by one, 1 steps by two |
| count_o | output | 8 | Current count |

## Verification
The assertions assume that `run_i` and `pair_i` are stable at each rising edge. They also assume the first edge is taken with `rst_n_i` low, so the count starts from a known value.

The bench meets these assumptions in three ways:
- It applies reset before anything else.
- It changes inputs only on the falling edge.
- It draws reset rarely, so random runs of enabled cycles reach both saturation points.

Directed sequences target the mode switches that matter most: from an odd count, at 255, at 254, and while counting is disabled.

// File: rtl/dual_step_pkg.sv
// Package: shared types for the dual-step saturating counter.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package dual_step_pkg;

    // Step mode selected by the step-select input.
    typedef enum logic {
        STEP_SINGLE = 1'b0,
        STEP_PAIR   = 1'b1
    } step_mode_e;

    // Width of the increment value (0, 1 or 2).
    localparam int unsigned INCR_W = 2;

endpackage

// File: rtl/dual_step_incr.sv
// Module: dual_step_incr
// Chooses the increment and the ceiling for the next count from the
// current count and the step mode.
// Assumes: count is CNT_W bits wide and CNT_W >= 2.
module dual_step_incr
    import dual_step_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0]  count_i,
    input  step_mode_e        mode_i,
    output logic [INCR_W-1:0] incr_o,
    output logic [CNT_W-1:0]  ceil_o
);

    localparam logic [CNT_W-1:0] TOP_ALL  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP_EVEN = {{(CNT_W-1){1'b1}}, 1'b0};

    // Purpose: in pair mode an odd count gets +1 to realign, an even one +2.
    always_comb begin
        if (mode_i == STEP_PAIR) begin
            incr_o = count_i[0] ? INCR_W'(1) : INCR_W'(2);
            ceil_o = TOP_EVEN;
        end else begin
            incr_o = INCR_W'(1);
            ceil_o = TOP_ALL;
        end
    end

endmodule

// File: rtl/dual_step_satadd.sv
// Module: dual_step_satadd
// Adds a small increment to a value and clamps the result at a ceiling.
// Assumes: the ceiling fits in CNT_W bits. A sum above the ceiling, including
// a carry out of CNT_W bits, gives the ceiling.
module dual_step_satadd
    import dual_step_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0]  base_i,
    input  logic [INCR_W-1:0] incr_i,
    input  logic [CNT_W-1:0]  ceil_i,
    output logic [CNT_W-1:0]  sum_o
);

    localparam int unsigned EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] wide_sum;

    // Purpose: form the sum one bit wider so a carry out is never lost.
    always_comb begin
        wide_sum = {1'b0, base_i} + EXT_W'(incr_i);
    end

    // Purpose: clamp the sum to the ceiling.
    always_comb begin
        if (wide_sum > {1'b0, ceil_i}) begin
            sum_o = ceil_i;
        end else begin
            sum_o = wide_sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/dual_step_reg.sv
// Module: dual_step_reg
// Count register with a synchronous active-low clear and a load enable.
// Assumes: clear has priority over load.
module dual_step_reg #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] next_i,
    output logic [CNT_W-1:0] q_o
);

    // Purpose: clear on reset, otherwise take the next value when loading.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= next_i;
        end
    end

endmodule

// File: rtl/dual_step_sat_counter.sv
// Module: dual_step_sat_counter (top)
// Up counter that steps by one or by two and saturates instead of wrapping.
// In step-by-two mode the count is kept even (ceiling 254 for 8 bits).
// Assumes: run_i and pair_i are synchronous to clk_i. Reset is synchronous
// and active low.
module dual_step_sat_counter
    import dual_step_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             run_i,
    input  logic             pair_i,
    output logic [CNT_W-1:0] count_o
);

    step_mode_e        mode;
    logic [INCR_W-1:0] incr;
    logic [CNT_W-1:0]  ceil;
    logic [CNT_W-1:0]  next_count;

    // Purpose: map the step-select pin onto the mode type.
    always_comb begin
        mode = pair_i ? STEP_PAIR : STEP_SINGLE;
    end

    dual_step_incr #(.CNT_W(CNT_W)) u_incr (
        .count_i (count_o),
        .mode_i  (mode),
        .incr_o  (incr),
        .ceil_o  (ceil)
    );

    dual_step_satadd #(.CNT_W(CNT_W)) u_add (
        .base_i  (count_o),
        .incr_i  (incr),
        .ceil_i  (ceil),
        .sum_o   (next_count)
    );

    dual_step_reg #(.CNT_W(CNT_W)) u_reg (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .load_i  (run_i),
        .next_i  (next_count),
        .q_o     (count_o)
    );

endmodule

// File: rtl/dual_step_sat_counter_chk.sv
// Module: dual_step_sat_counter_chk
// Assertion checker bound to the counter top. It observes the ports only.
// Assumes: the first clock edge is taken with reset asserted.
module dual_step_sat_counter_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             run_i,
    input logic             pair_i,
    input logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] TOP_ALL  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP_EVEN = {{(CNT_W-1){1'b1}}, 1'b0};

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        !rst_n_i |=> count_o == '0);  // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !run_i |=> $stable(count_o));  // R2

    AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && !pair_i && count_o != TOP_ALL) |=> count_o == $past(count_o) + 1'b1);  // R3

    AST_SINGLE_SAT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && !pair_i && count_o == TOP_ALL) |=> count_o == TOP_ALL);  // R4

    AST_PAIR_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && pair_i && !count_o[0] && count_o < TOP_EVEN) |=> count_o == $past(count_o) + 2'd2);  // R5

    AST_PAIR_SAT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && pair_i) |=> count_o <= TOP_EVEN);  // R6

    AST_PAIR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && pair_i && count_o[0] && count_o != TOP_ALL) |=> count_o == $past(count_o) + 1'b1);  // R7

    AST_PAIR_EVEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && pair_i) |=> !count_o[0]);  // R8

endmodule

bind dual_step_sat_counter dual_step_sat_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dual_step_sat_counter_test.sv
// Bench: dual_step_sat_counter_test
// Directed corner cases plus seeded random stimulus, checked against a
// reference function written from the requirements.
module dual_step_sat_counter_test;

    logic       clk_i = 1'b0;
    logic       rst_n_i = 1'b0;
    logic       run_i = 1'b0;
    logic       pair_i = 1'b0;
    logic [7:0] count_o;

    int unsigned checks = 0;
    int unsigned fails = 0;
    logic [7:0]  expect_q = 8'd0;
    bit          finished = 1'b0;

    dual_step_sat_counter uut (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (run_i),
        .pair_i  (pair_i),
        .count_o (count_o)
    );

    always #2 clk_i = ~clk_i;

    // Reference next value, built from R1..R7.
    function automatic logic [7:0] ref_next(logic [7:0] c, logic rn, logic en, logic pr);
        if (!rn)            return 8'd0;
        else if (!en)       return c;
        else if (!pr)       return (c == 8'd255) ? 8'd255 : c + 8'd1;
        else if (c[0])      return (c == 8'd255) ? 8'd254 : c + 8'd1;
        else                return (c == 8'd254) ? 8'd254 : c + 8'd2;
    endfunction

    // Requirement that governs a given edge.
    function automatic string ref_tag(logic [7:0] c, logic rn, logic en, logic pr);
        if (!rn)            return "R1";
        else if (!en)       return "R2";
        else if (!pr)       return (c == 8'd255) ? "R4" : "R3";
        else if (c[0])      return "R7";
        else                return (c == 8'd254) ? "R6" : "R5";
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: count=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, sample on the next falling edge.
    task automatic cycle(logic rn, logic en, logic pr);
        string tag;
        rst_n_i = rn;
        run_i   = en;
        pair_i  = pr;
        tag      = ref_tag(expect_q, rn, en, pr);
        expect_q = ref_next(expect_q, rn, en, pr);
        @(posedge clk_i);
        @(negedge clk_i);
        check(tag, count_o, expect_q);
        if (rn && en && pr) check("R8", {7'd0, count_o[0]}, 8'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: count=%0d expected=%0d", count_o, expect_q);
        finish_run();
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_0017);
        @(negedge clk_i);
        // R1: reset state, and reset overriding an active enable and step-by-two.
        cycle(1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 1'b1);
        // R3/R4: count by one up to saturation.
        for (int i = 0; i < 260; i++) cycle(1'b1, 1'b1, 1'b0);
        // R2: enable low while the step select toggles.
        cycle(1'b1, 1'b0, 1'b1);
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b1, 1'b0, 1'b1);
        // R7: from 255 in pair mode down to 254; R6 holds there.
        cycle(1'b1, 1'b1, 1'b1);
        cycle(1'b1, 1'b1, 1'b1);
        // R1 then R3 to an odd value, then R7 realign and R5 stepping.
        cycle(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 140; i++) cycle(1'b1, 1'b1, 1'b1);
        // Single step from 254 to 255, then pair mode again.
        cycle(1'b1, 1'b1, 1'b0);
        cycle(1'b1, 1'b1, 1'b1);
        // Random mix with rare resets so both saturation points are reached.
        for (int i = 0; i < 4000; i++) begin
            logic rn, en, pr;
            rn = ($urandom % 512) != 0;
            en = ($urandom % 4) != 0;
            pr = ($urandom % 2) != 0;
            cycle(rn, en, pr);
        end
        finish_run();
    end

endmodule